// File: doc/BRIEF.md
# Mask-Programmed Dual Shift-Register Ranging Code Generator

The block generates one binary spreading chip per enabled clock from two 14-stage linear feedback shift registers. Which stages feed back, and which stages form the output chip, are not wired in. They are held as bit masks that software writes through a small register-write port. This lets the same hardware produce Gold codes, m-sequences and other shift-register codes. An arrangement bit chooses how the two registers are used. They can run side by side, each closing its own feedback loop. They can also be chained into a single 28-stage register, which is long enough for 27-stage codes.

All configuration is written into a staging bank first. A load command copies the staging bank into the working set and starts the code from its initial states. A code period register sets truncated code lengths. At the end of each period the initial states are reloaded, so a code such as a 10230-chip truncation of a long m-sequence repeats exactly. Stage numbering is 1-based: stage k of a register is bit k-1. In the chained arrangement, stages 1 to 14 are bits 0 to 13 of the first register and stages 15 to 28 are bits 0 to 13 of the second.

Top module: `dual_lfsr_codegen`

## Requirements
- R1: After reset every shift register stage, every staged and working configuration field and the period counter are zero, so `code_out` is 0 and stays 0 under `chip_en` until a load.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the staging field chosen by `cfg_addr`. The addresses are 0 first initial state, 1 second initial state, 2 first feedback mask, 3 second feedback mask, 4 first output mask, 5 second output mask, 6 period (`cfg_wdata[PERIOD_W-1:0]`), and 7 arrangement (`cfg_wdata[0]`, 1 = chained). A write has no effect on the running code until the next load.
- R3: A cycle with `load` high copies every staging field into the working set, loads the first register with the first initial state and the second with the second, and clears the period counter. `load` takes precedence over `chip_en` in the same cycle.
- R4: With `chip_en` and `load` both low, the register contents and `code_out` do not change.
- R5: In the side-by-side arrangement, each enabled chip shifts each register one stage toward its top bit. The parity of that register's stages selected by its own feedback mask enters its bit 0.
- R6: In the chained arrangement, each enabled chip shifts both registers, moves bit 13 of the first register into bit 0 of the second, and writes the parity of the masked stages of both registers into bit 0 of the first.
- R7: `code_out` is the parity of all stages selected by the two output masks across both registers, taken from the current register contents in both arrangements.
- R8: With a nonzero period P, the enabled chip that follows chip P-1 reloads both initial states instead of shifting, so the code repeats every P chips. With P = 0 the registers run freely without reload.
- R9: In the chained arrangement, the masks can realise the 27-stage Fibonacci m-sequence with polynomial 1+x^3+x^4+x^5+x^6+x^9+x^11+x^13+x^16+x^19+x^21+x^24+x^27, with the output taken from stage 27.
- R10: In the side-by-side arrangement, the masks can realise the 10-stage Gold pair 1+x^3+x^10 and 1+x^2+x^3+x^6+x^8+x^9+x^10, with the output being stage 10 of each register XORed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_addr | input | 3 | Staging register select |
| cfg_wdata | input | DATA_W | Staging register write data |
| load | input | 1 | Commit staging bank and restart code |
| chip_en | input | 1 | Advance the code by one chip |
| code_out | output | 1 | Current code chip |

## Verification
The code is compared chip by chip with a tap-list recurrence model in four patterns. The first is the 10-stage Gold pair with an all-ones start and a full 1023-chip period, which separates feedback tap errors from output tap errors. The second is the 27-stage chained m-sequence truncated at 10230 chips, which exercises the inter-register carry and the period reload at the truncation point. The third is a side-by-side run with an odd start and a 300-chip period, and the fourth is a free-running chained run with period zero, which separates reload-on-wrap from free running. Configuration writes are placed in the middle of a running code and followed by a load coinciding with `chip_en`, to show that staging isolation and load precedence both hold.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

   // Staging register select codes
   typedef enum logic [2:0] {
      CFG_INIT_A  = 3'd0,
      CFG_INIT_B  = 3'd1,
      CFG_FB_A    = 3'd2,
      CFG_FB_B    = 3'd3,
      CFG_OUT_A   = 3'd4,
      CFG_OUT_B   = 3'd5,
      CFG_PERIOD  = 3'd6,
      CFG_ARRANGE = 3'd7
   } cfg_sel_e;

   // Register arrangement
   typedef enum logic {
      ARR_SPLIT   = 1'b0,
      ARR_CHAINED = 1'b1
   } arrange_e;

   localparam int NUM_SEG = 2;

endpackage

// File: rtl/dlc_cfg_bank.sv
module dlc_cfg_bank
   import dlc_pkg::*;
#(
   parameter int SEG_W    = 14,
   parameter int PERIOD_W = 20,
   parameter int DATA_W   = 20,
   parameter int NSEG     = NUM_SEG
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [2:0]                 cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   input  logic                       commit,
   output logic [NSEG-1:0][SEG_W-1:0] stg_init,
   output logic [NSEG-1:0][SEG_W-1:0] act_init,
   output logic [NSEG-1:0][SEG_W-1:0] act_fb,
   output logic [NSEG-1:0][SEG_W-1:0] act_out,
   output logic [PERIOD_W-1:0]        act_period,
   output logic                       act_mode
);

   logic [NSEG-1:0][SEG_W-1:0] stg_fb;
   logic [NSEG-1:0][SEG_W-1:0] stg_out;
   logic [PERIOD_W-1:0]        stg_period;
   logic                       stg_mode;
   logic [SEG_W-1:0]           wr_seg;

   assign wr_seg = cfg_wdata[SEG_W-1:0];

   // Staging bank: written by software, never seen by the shift logic
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_init   <= '0;
         stg_fb     <= '0;
         stg_out    <= '0;
         stg_period <= '0;
         stg_mode   <= ARR_SPLIT;
      end else if (cfg_we) begin
         case (cfg_sel_e'(cfg_addr))
            CFG_INIT_A:  stg_init[0] <= wr_seg;
            CFG_INIT_B:  stg_init[1] <= wr_seg;
            CFG_FB_A:    stg_fb[0]   <= wr_seg;
            CFG_FB_B:    stg_fb[1]   <= wr_seg;
            CFG_OUT_A:   stg_out[0]  <= wr_seg;
            CFG_OUT_B:   stg_out[1]  <= wr_seg;
            CFG_PERIOD:  stg_period  <= cfg_wdata[PERIOD_W-1:0];
            CFG_ARRANGE: stg_mode    <= cfg_wdata[0];
            default:     stg_mode    <= stg_mode;
         endcase
      end
   end

   // Working set: changes only on commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_init   <= '0;
         act_fb     <= '0;
         act_out    <= '0;
         act_period <= '0;
         act_mode   <= ARR_SPLIT;
      end else if (commit) begin
         act_init   <= stg_init;
         act_fb     <= stg_fb;
         act_out    <= stg_out;
         act_period <= stg_period;
         act_mode   <= stg_mode;
      end
   end

endmodule

// File: rtl/dlc_shift_seg.sv
module dlc_shift_seg #(
   parameter int SEG_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [SEG_W-1:0] reload_val,
   input  logic             shift,
   input  logic             ser_in,
   input  logic [SEG_W-1:0] fb_mask,
   input  logic [SEG_W-1:0] out_mask,
   output logic [SEG_W-1:0] state,
   output logic             fb_par,
   output logic             out_par,
   output logic             top_bit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
      end else if (reload) begin
         state <= reload_val;
      end else if (shift) begin
         state <= {state[SEG_W-2:0], ser_in};
      end
   end

   assign fb_par  = ^(state & fb_mask);
   assign out_par = ^(state & out_mask);
   assign top_bit = state[SEG_W-1];

endmodule

// File: rtl/dlc_period_ctr.sv
module dlc_period_ctr #(
   parameter int PERIOD_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic                advance,
   input  logic [PERIOD_W-1:0] period,
   output logic [PERIOD_W-1:0] cnt,
   output logic                wrap
);

   localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

   assign wrap = advance && (period != '0) && (cnt == period - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || wrap) begin
         cnt <= '0;
      end else if (advance) begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/dual_lfsr_codegen.sv
module dual_lfsr_codegen
   import dlc_pkg::*;
#(
   parameter int SEG_W    = 14,
   parameter int PERIOD_W = 20,
   parameter int DATA_W   = 20,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              load,
   input  logic              chip_en,
   output logic              code_out
);

   localparam int NSEG = NUM_SEG;

   // Elaboration-time parameter checks
   if (SEG_W < 2) begin : g_bad_seg
      $error("dual_lfsr_codegen: SEG_W must be at least 2");
   end
   if (DATA_W < SEG_W || DATA_W < PERIOD_W) begin : g_bad_data
      $error("dual_lfsr_codegen: DATA_W must cover SEG_W and PERIOD_W");
   end
   if (PERIOD_W < 1) begin : g_bad_period
      $error("dual_lfsr_codegen: PERIOD_W must be positive");
   end

   logic [NSEG-1:0][SEG_W-1:0] stg_init;
   logic [NSEG-1:0][SEG_W-1:0] act_init;
   logic [NSEG-1:0][SEG_W-1:0] act_fb;
   logic [NSEG-1:0][SEG_W-1:0] act_out;
   logic [PERIOD_W-1:0]        act_period;
   logic                       act_mode;
   logic [PERIOD_W-1:0]        period_cnt;
   logic                       wrap;
   logic                       advance;
   logic                       chained;

   logic [NSEG-1:0][SEG_W-1:0] seg_state;
   logic [NSEG-1:0]            fb_par;
   logic [NSEG-1:0]            out_par;
   logic [NSEG-1:0]            top_bit;
   logic [NSEG-1:0]            ser_in;

   assign advance = chip_en & ~load;

   dlc_cfg_bank #(
      .SEG_W    (SEG_W),
      .PERIOD_W (PERIOD_W),
      .DATA_W   (DATA_W),
      .NSEG     (NSEG)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .commit     (load),
      .stg_init   (stg_init),
      .act_init   (act_init),
      .act_fb     (act_fb),
      .act_out    (act_out),
      .act_period (act_period),
      .act_mode   (act_mode)
   );

   dlc_period_ctr #(
      .PERIOD_W (PERIOD_W)
   ) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .advance (advance),
      .period  (act_period),
      .cnt     (period_cnt),
      .wrap    (wrap)
   );

   // Chaining variant
   if (CHAIN_EN) begin : g_chain
      assign chained = (act_mode == ARR_CHAINED);
   end else begin : g_no_chain
      assign chained = 1'b0;
   end

   // Serial inputs for each segment
   always_comb begin
      if (chained) begin
         ser_in[0] = ^fb_par;
         ser_in[1] = top_bit[0];
      end else begin
         ser_in = fb_par;
      end
   end

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      dlc_shift_seg #(
         .SEG_W (SEG_W)
      ) u_seg (
         .clk        (clk),
         .rst_n      (rst_n),
         .reload     (load | wrap),
         .reload_val (load ? stg_init[i] : act_init[i]),
         .shift      (advance & ~wrap),
         .ser_in     (ser_in[i]),
         .fb_mask    (act_fb[i]),
         .out_mask   (act_out[i]),
         .state      (seg_state[i]),
         .fb_par     (fb_par[i]),
         .out_par    (out_par[i]),
         .top_bit    (top_bit[i])
      );
   end

   assign code_out = ^out_par;

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
   parameter int SEG_W    = 14,
   parameter int PERIOD_W = 20
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    load,
   input logic                    chip_en,
   input logic                    cfg_we,
   input logic                    code_out,
   input logic [1:0][SEG_W-1:0]   seg_state,
   input logic [1:0][SEG_W-1:0]   stg_init,
   input logic [1:0][SEG_W-1:0]   act_init,
   input logic [1:0][SEG_W-1:0]   act_fb,
   input logic [1:0][SEG_W-1:0]   act_out,
   input logic [PERIOD_W-1:0]     act_period,
   input logic                    act_mode,
   input logic [PERIOD_W-1:0]     period_cnt
);

   localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

   logic at_end;
   assign at_end = (act_period != '0) && (period_cnt == act_period - ONE);

   assert_cfg_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !load |=> $stable(act_init) && $stable(act_fb) && $stable(act_out)
                          && $stable(act_period) && $stable(act_mode));

   assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (seg_state == $past(stg_init)) && (period_cnt == '0));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en && !load |=> $stable(seg_state) && $stable(code_out));

   assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en && !load && !at_end |=>
         (seg_state[0][SEG_W-1:1] == $past(seg_state[0][SEG_W-2:0])) &&
         (seg_state[1][SEG_W-1:1] == $past(seg_state[1][SEG_W-2:0])));

   assert_chain_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_mode && chip_en && !load && !at_end |=>
         seg_state[1][0] == $past(seg_state[0][SEG_W-1]));

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_period != '0) |-> (period_cnt < act_period));

   assert_wrap_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en && !load && at_end |=> (period_cnt == '0) && (seg_state == act_init));

endmodule

bind dual_lfsr_codegen dlc_checker #(
   .SEG_W    (SEG_W),
   .PERIOD_W (PERIOD_W)
) u_dlc_checker (.*);

// File: tb/tb_dual_lfsr_codegen.sv
module tb_dual_lfsr_codegen;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          load = 1'b0;
   logic          chip_en = 1'b0;
   logic          code_out;

   dual_lfsr_codegen dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .load      (load),
      .chip_en   (chip_en),
      .code_out  (code_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec  = 0;
   int n_fail = 0;
   int chip_no = 0;
   bit done = 0;

   // ---------------- reference model ----------------
   // staged and active configuration (values as software sees them)
   int st_init1 = 0, st_init2 = 0, st_period = 0, st_mode = 0;
   int ac_init1 = 0, ac_init2 = 0, ac_period = 0, ac_mode = 0;
   int cnt = 0;
   // history queues: index 0 is the newest bit (stage 1)
   bit h1[$];
   bit h2[$];
   bit hm[$];
   int taps_g1[$]  = '{3, 10};
   int taps_g2[$]  = '{2, 3, 6, 8, 9, 10};
   int taps_m27[$] = '{3, 4, 5, 6, 9, 11, 13, 16, 19, 21, 24, 27};

   task automatic model_restart();
      h1.delete(); h2.delete(); hm.delete();
      for (int k = 0; k < 14; k++) begin
         h1.push_back(bit'((ac_init1 >> k) & 1));
         h2.push_back(bit'((ac_init2 >> k) & 1));
      end
      for (int k = 0; k < 14; k++) hm.push_back(h1[k]);
      for (int k = 0; k < 14; k++) hm.push_back(h2[k]);
      cnt = 0;
   endtask

   task automatic model_commit();
      ac_init1 = st_init1; ac_init2 = st_init2;
      ac_period = st_period; ac_mode = st_mode;
      model_restart();
      chip_no = 0;
   endtask

   function automatic bit model_out();
      if (ac_mode != 0) return hm[26];
      return h1[9] ^ h2[9];
   endfunction

   task automatic model_shift();
      bit n1, n2;
      if (ac_period != 0 && cnt == ac_period - 1) begin
         model_restart();
         return;
      end
      cnt++;
      if (ac_mode != 0) begin
         n1 = 0;
         foreach (taps_m27[i]) n1 ^= hm[taps_m27[i]-1];
         hm.push_front(n1);
         void'(hm.pop_back());
      end else begin
         n1 = 0; n2 = 0;
         foreach (taps_g1[i]) n1 ^= h1[taps_g1[i]-1];
         foreach (taps_g2[i]) n2 ^= h2[taps_g2[i]-1];
         h1.push_front(n1); void'(h1.pop_back());
         h2.push_front(n2); void'(h2.pop_back());
      end
   endtask

   // ---------------- checking and driving ----------------
   task automatic check(bit act, bit exp, string req);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: code_out=%0b expected %0b (chip %0d)", req, act, exp, chip_no);
      end
   endtask

   task automatic step_chip(string req);
      @(negedge clk);
      check(code_out, model_out(), req);
      chip_en = 1'b1;
      @(posedge clk);
      #1;
      chip_en = 1'b0;
      model_shift();
      chip_no++;
   endtask

   task automatic idle_cycle(string req);
      @(negedge clk);
      check(code_out, model_out(), req);
   endtask

   task automatic cfg_write(int addr, int data);
      @(negedge clk);
      check(code_out, model_out(), "R2");
      cfg_we = 1'b1;
      cfg_addr = 3'(addr);
      cfg_wdata = DW'(data);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      case (addr)
         0: st_init1 = data & 16'h3FFF;
         1: st_init2 = data & 16'h3FFF;
         6: st_period = data;
         7: st_mode = data & 1;
         default: ;
      endcase
   endtask

   task automatic do_load(bit with_en);
      @(negedge clk);
      load = 1'b1;
      chip_en = with_en;
      @(posedge clk);
      #1;
      load = 1'b0;
      chip_en = 1'b0;
      model_commit();
   endtask

   task automatic write_all(int i1, int i2, int f1, int f2, int o1, int o2, int per, int mode);
      cfg_write(0, i1); cfg_write(1, i2);
      cfg_write(2, f1); cfg_write(3, f2);
      cfg_write(4, o1); cfg_write(5, o2);
      cfg_write(6, per); cfg_write(7, mode);
   endtask

   // Watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      model_restart();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state, zero output even while chipping
      idle_cycle("R1");
      for (int i = 0; i < 20; i++) step_chip("R1");

      // R2: staging writes for the Gold pair do not reach the running code
      write_all(16'h3FF, 16'h3FF, 16'h204, 16'h3A6, 16'h200, 16'h200, 1023, 0);
      for (int i = 0; i < 10; i++) step_chip("R2");

      // R10/R7/R8: Gold pair, full period and wrap
      do_load(1'b0);
      for (int i = 0; i < 1100; i++) begin
         if (i < 16) step_chip("R7");
         else if (i >= 1020 && i < 1028) step_chip("R8");
         else step_chip("R10");
      end

      // R4: hold with chip_en low
      for (int i = 0; i < 6; i++) idle_cycle("R4");

      // R2: chained configuration staged mid-code, split code continues
      write_all(16'h2A5B, 16'h0C31, 16'h153C, 16'h1252, 0, 16'h1000, 10230, 1);
      for (int i = 0; i < 200; i++) step_chip("R5");

      // R3: load wins over simultaneous chip_en
      do_load(1'b1);
      idle_cycle("R3");

      // R9/R6/R8: 27-stage sequence truncated at 10230
      for (int i = 0; i < 10300; i++) begin
         if (i < 40) step_chip("R6");
         else if (i >= 10226 && i < 10236) step_chip("R8");
         else step_chip("R9");
      end

      // R5/R8: side-by-side, odd start, 300-chip period
      write_all(16'h155, 16'h2E1, 16'h204, 16'h3A6, 16'h200, 16'h200, 300, 0);
      do_load(1'b0);
      for (int i = 0; i < 700; i++) step_chip(i % 300 > 296 || i % 300 < 2 ? "R8" : "R5");

      // R8: chained, period 0 free-running
      write_all(16'h0001, 0, 16'h153C, 16'h1252, 0, 16'h1000, 0, 1);
      do_load(1'b0);
      for (int i = 0; i < 500; i++) step_chip("R8");
      for (int i = 0; i < 3; i++) idle_cycle("R4");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule